// File: doc/BRIEF.md
# Multi-Latency Bundle Issue Pipeline

This block is the issue and retirement control of a statically scheduled cluster of function units. Fixed-width instruction bundles are fetched in address order. Each bundle holds one slot per unit: one divider, two multipliers and two ALUs by default. A bundle moves through a fetch register, a decode register and an operand-read register, and then issues to the units. Each unit type has its own fixed execute time. A unit then hands its result to a shared write-back stage. The arithmetic itself is not in this block. Each unit is a latency-matched stub that carries only the destination of its operation, so the block's outputs are issue and write strobes with addresses.

Every destination has one pending bit in a scoreboard. A destination is one of the 32 entries of a unit's own local file, one of 64 scratch entries, or one of 64 data-memory words. A bundle waits in the read stage while any of its slots reads or writes a pending location, or needs a unit that is still occupied. While it waits, the front end holds and the execute stage receives a bubble. Work that issued earlier carries on and retires. When several results want the single scratch port or the single memory port in the same cycle, a fixed unit priority picks the winner. The other units keep their results until they win.

Top module: `vliw_exec_pipe`

## Requirements
- R1: While reset is asserted, `fetchAddr` is 0 and `issueFire`, `wbGrant`, `localWrEn`, `scratchWrEn` and `memWrEn` are all 0.
- R2: After reset is released, `fetchAddr` steps by one on every clock edge that does not occur during a stall. The bundle fetched from address i can issue no earlier than the cycle i+3, counting the first edge after release as cycle 1.
- R3: An operation that issues in cycle c is written in cycle c+L+1 if its write port is free. L is 2 for an ALU, 4 for a multiplier and 16 for the divider. A grant (`wbGrant[u]`) only happens for a unit holding a result.
- R4: A bundle with a slot whose source location is still pending waits. It issues in the cycle after the producing write, so a dependent bundle issues L+2 cycles after its producer.
- R5: A bundle with a slot whose destination location is still pending waits in the same way as in R4.
- R6: A unit is occupied from the cycle after its issue up to and including its write cycle. A bundle that uses an occupied unit waits, so back-to-back uses of one unit are L+2 cycles apart.
- R7: While `stall` is high, `fetchAddr` holds and nothing issues. Operations already issued keep counting down and keep writing.
- R8: The scratch port and the memory port each take at most one write per cycle. Unit index order is the priority, lowest first: divider (0), multipliers (1, 2), ALUs (3, 4). A losing unit keeps its result and asks again in the next cycle. Local writes never contend.
- R9: Bundle encoding. Slot u occupies `fetchWord[u*17 +: 17]`. Within a slot, bit 16 is valid, [15:14] is the source space, [13:8] is the source index, [7:6] is the destination space and [5:0] is the destination index. Space codes are 0 none, 1 own local file, 2 scratch, 3 memory. A local index uses only its low 5 bits. A bundle with no valid slot passes through the pipeline without issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchAddr | output | 10 | Address of the bundle being fetched |
| fetchWord | input | 85 | Bundle at `fetchAddr`, five 17-bit slots |
| issueFire | output | 1 | Bundle in the read stage issues this cycle |
| stall | output | 1 | Bundle in the read stage is held by a hazard |
| wbGrant | output | 5 | Unit u retires its result this cycle |
| localWrEn | output | 5 | Unit u writes its own local file |
| localWrAddr | output | 25 | Local write index of unit u at [u*5 +: 5] |
| scratchWrEn | output | 1 | Scratch port write strobe |
| scratchWrAddr | output | 6 | Scratch port write index |
| scratchWrUnit | output | 3 | Unit that owns the scratch write |
| memWrEn | output | 1 | Memory port write strobe |
| memWrAddr | output | 6 | Memory port write index |
| memWrUnit | output | 3 | Unit that owns the memory write |

## Verification
The bench uses the default build: one divider, two multipliers and two ALUs with latencies 16, 4 and 2, a 32-entry local file, 64-entry scratch and memory spaces, and a 10-bit fetch address. The 10-bit address keeps a 400-cycle run per program clear of address wrap-around. The 16-cycle divider lets an ALU issued 14 cycles after it finish in the same cycle, which brings the port priority of R8 within reach of a directed case. Random programs draw their indices from four values only, so read-after-write, write-after-write and busy-unit stalls overlap often. Each program is compared cycle by cycle with a bench model of the timing rules.

// File: rtl/vliw_pipe_pkg.sv
package vliw_pipe_pkg;

  localparam int IDX_W  = 6;
  localparam int SLOT_W = 17;

  typedef enum logic [1:0] {
    SP_NONE    = 2'd0,
    SP_LOCAL   = 2'd1,
    SP_SCRATCH = 2'd2,
    SP_MEM     = 2'd3
  } space_e;

  typedef struct packed {
    logic               valid;
    space_e             srcSp;
    logic [IDX_W-1:0]   srcIdx;
    space_e             dstSp;
    logic [IDX_W-1:0]   dstIdx;
  } slot_t;

  // strobe bundle handed from control to the unit datapath, one per unit
  typedef struct packed {
    logic             start;
    space_e           dstSp;
    logic [IDX_W-1:0] dstIdx;
  } issue_cmd_t;

endpackage

// File: rtl/vliw_issue_ctrl.sv
module vliw_issue_ctrl
  import vliw_pipe_pkg::*;
#(
  parameter int PC_W          = 10,
  parameter int NU            = 5,
  parameter int LOCAL_DEPTH   = 32,
  parameter int SCRATCH_DEPTH = 64,
  parameter int MEM_DEPTH     = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  output logic [PC_W-1:0]         fetchAddr,
  input  logic [NU*SLOT_W-1:0]    fetchWord,
  input  logic [NU-1:0]           busyVec,
  input  logic [NU-1:0]           wbGrant,
  input  space_e                  doneSp  [NU],
  input  logic [IDX_W-1:0]        doneIdx [NU],
  output issue_cmd_t              cmd     [NU],
  output logic                    issueFire,
  output logic                    stall
);

  localparam int LOC_W = $clog2(LOCAL_DEPTH);
  localparam int SCR_W = $clog2(SCRATCH_DEPTH);
  localparam int MEM_W = $clog2(MEM_DEPTH);

  logic [PC_W-1:0]          pc;
  logic                     fValid, dValid, rValid;
  logic [NU*SLOT_W-1:0]     fWord;
  slot_t                    decSlots [NU];
  slot_t                    dSlots   [NU];
  slot_t                    rSlots   [NU];

  logic [LOCAL_DEPTH-1:0]   locPend [NU];
  logic [SCRATCH_DEPTH-1:0] scrPend;
  logic [MEM_DEPTH-1:0]     memPend;

  logic hazard, rAny;

  assign fetchAddr = pc;

  function automatic logic pendHit(
    input space_e                   sp,
    input logic [IDX_W-1:0]         idx,
    input logic [LOCAL_DEPTH-1:0]   loc,
    input logic [SCRATCH_DEPTH-1:0] scr,
    input logic [MEM_DEPTH-1:0]     mem
  );
    case (sp)
      SP_LOCAL:   return loc[idx[LOC_W-1:0]];
      SP_SCRATCH: return scr[idx[SCR_W-1:0]];
      SP_MEM:     return mem[idx[MEM_W-1:0]];
      default:    return 1'b0;
    endcase
  endfunction

  // decode: split the fetched word into per-unit slots
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      decSlots[u] = slot_t'(fWord[u*SLOT_W +: SLOT_W]);
    end
  end

  // hazard detection in the read stage
  always_comb begin
    hazard = 1'b0;
    rAny   = 1'b0;
    for (int u = 0; u < NU; u++) begin
      if (rSlots[u].valid) begin
        rAny = 1'b1;
        if (busyVec[u]) hazard = 1'b1;
        if (pendHit(rSlots[u].srcSp, rSlots[u].srcIdx, locPend[u], scrPend, memPend))
          hazard = 1'b1;
        if (pendHit(rSlots[u].dstSp, rSlots[u].dstIdx, locPend[u], scrPend, memPend))
          hazard = 1'b1;
      end
    end
  end

  assign issueFire = rValid && rAny && !hazard;
  assign stall     = rValid && rAny && hazard;

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      cmd[u].start  = issueFire && rSlots[u].valid;
      cmd[u].dstSp  = rSlots[u].dstSp;
      cmd[u].dstIdx = rSlots[u].dstIdx;
    end
  end

  // fetch, decode and read registers: all freeze on a stall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      fValid <= 1'b0;
      dValid <= 1'b0;
      rValid <= 1'b0;
      fWord  <= '0;
      for (int u = 0; u < NU; u++) begin
        dSlots[u] <= '0;
        rSlots[u] <= '0;
      end
    end else if (!stall) begin
      pc     <= pc + 1'b1;
      fValid <= 1'b1;
      fWord  <= fetchWord;
      dValid <= fValid;
      rValid <= dValid;
      for (int u = 0; u < NU; u++) begin
        dSlots[u] <= fValid ? decSlots[u] : '0;
        rSlots[u] <= dSlots[u];
      end
    end
  end

  // scoreboard: set on issue, cleared on the granted write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < NU; u++) locPend[u] <= '0;
      scrPend <= '0;
      memPend <= '0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (wbGrant[u]) begin
          case (doneSp[u])
            SP_LOCAL:   locPend[u][doneIdx[u][LOC_W-1:0]] <= 1'b0;
            SP_SCRATCH: scrPend[doneIdx[u][SCR_W-1:0]]    <= 1'b0;
            SP_MEM:     memPend[doneIdx[u][MEM_W-1:0]]    <= 1'b0;
            default: ;
          endcase
        end
      end
      for (int u = 0; u < NU; u++) begin
        if (cmd[u].start) begin
          case (cmd[u].dstSp)
            SP_LOCAL:   locPend[u][cmd[u].dstIdx[LOC_W-1:0]] <= 1'b1;
            SP_SCRATCH: scrPend[cmd[u].dstIdx[SCR_W-1:0]]    <= 1'b1;
            SP_MEM:     memPend[cmd[u].dstIdx[MEM_W-1:0]]    <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/vliw_unit_path.sv
module vliw_unit_path
  import vliw_pipe_pkg::*;
#(
  parameter int NU            = 5,
  parameter int NUM_DIV       = 1,
  parameter int NUM_MUL       = 2,
  parameter int ALU_LAT       = 2,
  parameter int MUL_LAT       = 4,
  parameter int DIV_LAT       = 16,
  parameter int LOCAL_DEPTH   = 32,
  parameter int SCRATCH_DEPTH = 64,
  parameter int MEM_DEPTH     = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  issue_cmd_t                    cmd     [NU],
  output logic [NU-1:0]                 busyVec,
  output logic [NU-1:0]                 wbGrant,
  output space_e                        doneSp  [NU],
  output logic [IDX_W-1:0]              doneIdx [NU],
  output logic [NU-1:0]                 localWrEn,
  output logic [NU*$clog2(LOCAL_DEPTH)-1:0] localWrAddr,
  output logic                          scratchWrEn,
  output logic [$clog2(SCRATCH_DEPTH)-1:0] scratchWrAddr,
  output logic [$clog2(NU)-1:0]         scratchWrUnit,
  output logic                          memWrEn,
  output logic [$clog2(MEM_DEPTH)-1:0]  memWrAddr,
  output logic [$clog2(NU)-1:0]         memWrUnit
);

  localparam int LOC_W   = $clog2(LOCAL_DEPTH);
  localparam int SCR_W   = $clog2(SCRATCH_DEPTH);
  localparam int MEM_W   = $clog2(MEM_DEPTH);
  localparam int UW      = $clog2(NU);
  localparam int MAX_LAT = (DIV_LAT > MUL_LAT) ?
                           ((DIV_LAT > ALU_LAT) ? DIV_LAT : ALU_LAT) :
                           ((MUL_LAT > ALU_LAT) ? MUL_LAT : ALU_LAT);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [NU-1:0] holdVec;

  // latency-matched unit stubs: countdown then a result holding register
  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int LAT = (u < NUM_DIV) ? DIV_LAT :
                         (u < NUM_DIV + NUM_MUL) ? MUL_LAT : ALU_LAT;
    logic [CNT_W-1:0] cnt;
    logic             hold;
    space_e           sp;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        hold <= 1'b0;
        sp   <= SP_NONE;
        idx  <= '0;
      end else begin
        if (cmd[u].start) begin
          cnt <= CNT_W'(LAT);
          sp  <= cmd[u].dstSp;
          idx <= cmd[u].dstIdx;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) hold <= 1'b1;
        end
        if (wbGrant[u]) hold <= 1'b0;
      end
    end

    assign busyVec[u] = (cnt != '0) || hold;
    assign holdVec[u] = hold;
    assign doneSp[u]  = sp;
    assign doneIdx[u] = idx;
  end

  // write-back arbitration: lowest unit index wins a shared port
  always_comb begin
    logic scrTaken, memTaken;
    scrTaken      = 1'b0;
    memTaken      = 1'b0;
    wbGrant       = '0;
    localWrEn     = '0;
    localWrAddr   = '0;
    scratchWrAddr = '0;
    scratchWrUnit = '0;
    memWrAddr     = '0;
    memWrUnit     = '0;
    for (int u = 0; u < NU; u++) begin
      if (holdVec[u]) begin
        case (doneSp[u])
          SP_SCRATCH: begin
            if (!scrTaken) begin
              scrTaken      = 1'b1;
              wbGrant[u]    = 1'b1;
              scratchWrAddr = doneIdx[u][SCR_W-1:0];
              scratchWrUnit = UW'(u);
            end
          end
          SP_MEM: begin
            if (!memTaken) begin
              memTaken   = 1'b1;
              wbGrant[u] = 1'b1;
              memWrAddr  = doneIdx[u][MEM_W-1:0];
              memWrUnit  = UW'(u);
            end
          end
          SP_LOCAL: begin
            wbGrant[u]   = 1'b1;
            localWrEn[u] = 1'b1;
            localWrAddr[u*LOC_W +: LOC_W] = doneIdx[u][LOC_W-1:0];
          end
          default: wbGrant[u] = 1'b1;
        endcase
      end
    end
    scratchWrEn = scrTaken;
    memWrEn     = memTaken;
  end

endmodule

// File: rtl/vliw_exec_pipe.sv
module vliw_exec_pipe
  import vliw_pipe_pkg::*;
#(
  parameter int PC_W          = 10,
  parameter int NUM_DIV       = 1,
  parameter int NUM_MUL       = 2,
  parameter int NUM_ALU       = 2,
  parameter int ALU_LAT       = 2,
  parameter int MUL_LAT       = 4,
  parameter int DIV_LAT       = 16,
  parameter int LOCAL_DEPTH   = 32,
  parameter int SCRATCH_DEPTH = 64,
  parameter int MEM_DEPTH     = 64,
  localparam int NU           = NUM_DIV + NUM_MUL + NUM_ALU,
  localparam int UW           = $clog2(NU),
  localparam int LOC_W        = $clog2(LOCAL_DEPTH),
  localparam int SCR_W        = $clog2(SCRATCH_DEPTH),
  localparam int MEM_W        = $clog2(MEM_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  output logic [PC_W-1:0]       fetchAddr,
  input  logic [NU*SLOT_W-1:0]  fetchWord,
  output logic                  issueFire,
  output logic                  stall,
  output logic [NU-1:0]         wbGrant,
  output logic [NU-1:0]         localWrEn,
  output logic [NU*LOC_W-1:0]   localWrAddr,
  output logic                  scratchWrEn,
  output logic [SCR_W-1:0]      scratchWrAddr,
  output logic [UW-1:0]         scratchWrUnit,
  output logic                  memWrEn,
  output logic [MEM_W-1:0]      memWrAddr,
  output logic [UW-1:0]         memWrUnit
);

  issue_cmd_t       cmd     [NU];
  logic [NU-1:0]    busyVec;
  space_e           doneSp  [NU];
  logic [IDX_W-1:0] doneIdx [NU];

  vliw_issue_ctrl #(
    .PC_W(PC_W), .NU(NU), .LOCAL_DEPTH(LOCAL_DEPTH),
    .SCRATCH_DEPTH(SCRATCH_DEPTH), .MEM_DEPTH(MEM_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .fetchWord(fetchWord),
    .busyVec(busyVec), .wbGrant(wbGrant), .doneSp(doneSp), .doneIdx(doneIdx),
    .cmd(cmd), .issueFire(issueFire), .stall(stall)
  );

  vliw_unit_path #(
    .NU(NU), .NUM_DIV(NUM_DIV), .NUM_MUL(NUM_MUL), .ALU_LAT(ALU_LAT),
    .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT), .LOCAL_DEPTH(LOCAL_DEPTH),
    .SCRATCH_DEPTH(SCRATCH_DEPTH), .MEM_DEPTH(MEM_DEPTH)
  ) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busyVec(busyVec), .wbGrant(wbGrant),
    .doneSp(doneSp), .doneIdx(doneIdx), .localWrEn(localWrEn),
    .localWrAddr(localWrAddr), .scratchWrEn(scratchWrEn),
    .scratchWrAddr(scratchWrAddr), .scratchWrUnit(scratchWrUnit),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrUnit(memWrUnit)
  );

endmodule

// File: rtl/vliw_exec_pipe_chk.sv
module vliw_exec_pipe_chk #(
  parameter int PC_W = 10,
  parameter int NU   = 5,
  parameter int UW   = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] fetchAddr,
  input logic            stall,
  input logic            issueFire,
  input logic [NU-1:0]   wbGrant,
  input logic [NU-1:0]   busyVec,
  input logic            scratchWrEn,
  input logic [UW-1:0]   scratchWrUnit,
  input logic            memWrEn,
  input logic [UW-1:0]   memWrUnit
);

  p_fetch_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(fetchAddr));

  p_fetch_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stall |=> fetchAddr == PC_W'($past(fetchAddr) + 1'b1));

  p_no_issue_in_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !issueFire);

  p_scratch_owner_r8: assert property (@(posedge clk) disable iff (!rstN)
    scratchWrEn |-> wbGrant[scratchWrUnit]);

  p_mem_owner_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> wbGrant[memWrUnit]);

  p_grant_needs_result_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wbGrant & ~busyVec) == '0);

  p_unit_busy_after_issue_r6: assert property (@(posedge clk) disable iff (!rstN)
    issueFire |=> busyVec != '0);

endmodule

bind vliw_exec_pipe vliw_exec_pipe_chk #(.PC_W(PC_W), .NU(NU), .UW(UW)) u_chk (
  .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .stall(stall),
  .issueFire(issueFire), .wbGrant(wbGrant), .busyVec(busyVec),
  .scratchWrEn(scratchWrEn), .scratchWrUnit(scratchWrUnit),
  .memWrEn(memWrEn), .memWrUnit(memWrUnit)
);

// File: tb/sim_vliw_exec_pipe.sv
module sim_vliw_exec_pipe;

  localparam int NU   = 5;
  localparam int SW   = 17;
  localparam int WW   = NU * SW;
  localparam int MAXC = 400;
  localparam int PMAX = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [9:0]     fetchAddr;
  logic [WW-1:0]  fetchWord;
  logic           issueFire, stall;
  logic [NU-1:0]  wbGrant, localWrEn;
  logic [24:0]    localWrAddr;
  logic           scratchWrEn, memWrEn;
  logic [5:0]     scratchWrAddr, memWrAddr;
  logic [2:0]     scratchWrUnit, memWrUnit;

  always #4 clk = ~clk;

  logic [WW-1:0] prog [PMAX];
  int progLen;
  assign fetchWord = (fetchAddr < 10'(PMAX)) ? prog[fetchAddr[4:0]] : '0;

  vliw_exec_pipe u0 (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .fetchWord(fetchWord),
    .issueFire(issueFire), .stall(stall), .wbGrant(wbGrant),
    .localWrEn(localWrEn), .localWrAddr(localWrAddr),
    .scratchWrEn(scratchWrEn), .scratchWrAddr(scratchWrAddr),
    .scratchWrUnit(scratchWrUnit), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrUnit(memWrUnit)
  );

  int errors = 0;
  int checks = 0;

  // bench model state
  int         mCnt [NU];
  bit         mHold[NU];
  int         mSp  [NU];
  int         mIdx [NU];
  bit [31:0]  mLoc [NU];
  bit [63:0]  mScr, mMem;
  int         expIss [64];
  int         expN;
  bit [63:0]  expW [MAXC];

  int         obsIss [64];
  int         obsN;
  bit [63:0]  obsW [MAXC];
  int         cyc;
  bit         running = 1'b0;
  bit         prevStall;
  logic [9:0] prevAddr;

  function automatic int latOf(int u);
    return (u == 0) ? 16 : (u < 3) ? 4 : 2;
  endfunction

  function automatic bit [SW-1:0] mkSlot(int sSp, int sIdx, int dSp, int dIdx);
    return {1'b1, 2'(sSp), 6'(sIdx), 2'(dSp), 6'(dIdx)};
  endfunction

  function automatic bit pendM(int u, int sp, int idx);
    case (sp)
      1: return mLoc[u][idx % 32];
      2: return mScr[idx];
      3: return mMem[idx];
      default: return 1'b0;
    endcase
  endfunction

  task automatic setPend(int u, int sp, int idx, bit val);
    case (sp)
      1: mLoc[u][idx % 32] = val;
      2: mScr[idx] = val;
      3: mMem[idx] = val;
      default: ;
    endcase
  endtask

  // timing model built from the requirements
  task automatic buildModel();
    int rIdx, rReady;
    for (int u = 0; u < NU; u++) begin
      mCnt[u] = 0; mHold[u] = 0; mSp[u] = 0; mIdx[u] = 0; mLoc[u] = '0;
    end
    mScr = '0; mMem = '0; expN = 0; rIdx = 0; rReady = 3;
    for (int t = 0; t < MAXC; t++) begin
      bit [NU-1:0] g, st;
      bit scrT, memT;
      bit [63:0] v;
      g = '0; st = '0; scrT = 0; memT = 0; v = '0;
      for (int u = 0; u < NU; u++) begin
        if (mHold[u]) begin
          if (mSp[u] == 2) begin
            if (!scrT) begin scrT = 1; g[u] = 1; v[41:36] = 6'(mIdx[u]); end
          end else if (mSp[u] == 3) begin
            if (!memT) begin memT = 1; g[u] = 1; v[48:43] = 6'(mIdx[u]); end
          end else begin
            g[u] = 1;
            if (mSp[u] == 1) begin
              v[5+u] = 1'b1;
              v[10+u*5 +: 5] = 5'(mIdx[u] % 32);
            end
          end
        end
      end
      v[4:0] = g; v[35] = scrT; v[42] = memT;
      expW[t] = v;
      if (rIdx < progLen && t >= rReady) begin
        bit hz, any;
        hz = 0; any = 0;
        for (int u = 0; u < NU; u++) begin
          bit [SW-1:0] s;
          s = prog[rIdx][u*SW +: SW];
          if (s[16]) begin
            any = 1;
            if (mCnt[u] != 0 || mHold[u]) hz = 1;
            if (pendM(u, int'(s[15:14]), int'(s[13:8]))) hz = 1;
            if (pendM(u, int'(s[7:6]), int'(s[5:0]))) hz = 1;
          end
        end
        if (!hz) begin
          if (any) begin
            expIss[expN] = t; expN++;
            for (int u = 0; u < NU; u++) st[u] = prog[rIdx][u*SW + 16];
          end
          rIdx++;
          rReady = (rIdx + 3 > t + 1) ? rIdx + 3 : t + 1;
        end
      end
      for (int u = 0; u < NU; u++) begin
        if (g[u]) begin setPend(u, mSp[u], mIdx[u], 1'b0); mHold[u] = 0; end
        if (mCnt[u] != 0) begin
          if (mCnt[u] == 1) mHold[u] = 1;
          mCnt[u]--;
        end
      end
      for (int u = 0; u < NU; u++) begin
        if (st[u]) begin
          bit [SW-1:0] s;
          s = prog[rIdx-1][u*SW +: SW];
          mCnt[u] = latOf(u); mSp[u] = int'(s[7:6]); mIdx[u] = int'(s[5:0]);
          setPend(u, mSp[u], mIdx[u], 1'b1);
        end
      end
    end
  endtask

  function automatic bit [63:0] packPorts();
    bit [63:0] v;
    v = '0;
    v[4:0] = wbGrant; v[9:5] = localWrEn; v[34:10] = localWrAddr;
    v[35] = scratchWrEn; v[41:36] = scratchEn(scratchWrAddr);
    v[42] = memWrEn; v[48:43] = memWrEn ? memWrAddr : 6'd0;
    return v;
  endfunction

  function automatic bit [5:0] scratchEn(logic [5:0] a);
    return scratchWrEn ? a : 6'd0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (running && cyc < MAXC) begin
      obsW[cyc] = packPorts();
      if (issueFire && obsN < 64) begin obsIss[obsN] = cyc; obsN++; end
      if (prevStall) begin
        checks++;
        if (fetchAddr !== prevAddr) begin
          errors++;
          $display("FAIL R7 fetch moved in stall cycle %0d got %0d exp %0d", cyc, fetchAddr, prevAddr);
        end
      end
      prevStall = stall;
      prevAddr  = fetchAddr;
    end
  end

  task automatic clearProg();
    for (int i = 0; i < PMAX; i++) prog[i] = '0;
    progLen = 0;
  endtask

  task automatic runTest(string tag);
    rstN = 1'b0;
    running = 1'b0;
    obsN = 0; prevStall = 0; prevAddr = '0;
    for (int t = 0; t < MAXC; t++) obsW[t] = '0;
    buildModel();
    repeat (3) @(negedge clk);
    checks++;
    if (fetchAddr !== 10'd0 || issueFire !== 1'b0 || wbGrant !== '0 ||
        localWrEn !== '0 || scratchWrEn !== 1'b0 || memWrEn !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state got addr=%0d iss=%b grant=%b exp 0", fetchAddr, issueFire, wbGrant);
    end
    rstN = 1'b1;
    running = 1'b1;
    repeat (MAXC + 1) @(negedge clk);
    running = 1'b0;
    checks++;
    if (obsN != expN) begin
      errors++;
      $display("FAIL %s issue count got %0d exp %0d", tag, obsN, expN);
    end
    for (int i = 0; i < expN && i < obsN; i++) begin
      checks++;
      if (obsIss[i] != expIss[i]) begin
        errors++;
        $display("FAIL %s issue %0d cycle got %0d exp %0d", tag, i, obsIss[i], expIss[i]);
      end
    end
    for (int t = 0; t < MAXC; t++) begin
      if (expW[t] != 0 || obsW[t] != 0) begin
        checks++;
        if (expW[t] != obsW[t]) begin
          errors++;
          $display("FAIL R3 R8 %s writes cycle %0d got %h exp %h", tag, t, obsW[t], expW[t]);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R2 R3: independent ops of each latency, back to back
    clearProg();
    prog[0][3*SW +: SW] = mkSlot(0, 0, 2, 1);
    prog[1][1*SW +: SW] = mkSlot(0, 0, 2, 2);
    prog[2][0*SW +: SW] = mkSlot(0, 0, 3, 3);
    progLen = 3;
    runTest("R2 R3");

    // R4: read after write through scratch and memory
    clearProg();
    prog[0][3*SW +: SW] = mkSlot(0, 0, 2, 5);
    prog[1][4*SW +: SW] = mkSlot(2, 5, 3, 7);
    prog[2][2*SW +: SW] = mkSlot(3, 7, 2, 8);
    progLen = 3;
    runTest("R4");

    // R5: write after write on one memory word
    clearProg();
    prog[0][0*SW +: SW] = mkSlot(0, 0, 3, 9);
    prog[1][3*SW +: SW] = mkSlot(0, 0, 3, 9);
    progLen = 2;
    runTest("R5");

    // R6 R7: same unit twice, older work writes during the stall
    clearProg();
    prog[0][0*SW +: SW] = mkSlot(0, 0, 2, 1);
    prog[1][0*SW +: SW] = mkSlot(0, 0, 2, 2);
    prog[2][3*SW +: SW] = mkSlot(0, 0, 1, 4);
    progLen = 3;
    runTest("R6 R7");

    // R8: same-cycle finishes on shared ports
    clearProg();
    prog[0][3*SW +: SW] = mkSlot(0, 0, 2, 1);
    prog[0][4*SW +: SW] = mkSlot(0, 0, 2, 2);
    prog[0][1*SW +: SW] = mkSlot(0, 0, 3, 3);
    prog[0][2*SW +: SW] = mkSlot(0, 0, 3, 4);
    progLen = 1;
    runTest("R8");

    // R8: divider beats an ALU that finishes in the same cycle
    clearProg();
    prog[0][0*SW +: SW] = mkSlot(0, 0, 2, 9);
    prog[14][3*SW +: SW] = mkSlot(0, 0, 2, 10);
    progLen = 15;
    runTest("R8");

    // R9: empty bundles issue nothing, local index uses low 5 bits
    clearProg();
    prog[1][3*SW +: SW] = mkSlot(0, 0, 1, 33);
    prog[3][4*SW +: SW] = mkSlot(1, 2, 1, 63);
    progLen = 5;
    runTest("R9");

    // random mixes with dense dependencies
    for (int p = 0; p < 6; p++) begin
      clearProg();
      for (int b = 0; b < 12; b++) begin
        for (int u = 0; u < NU; u++) begin
          if ($urandom % 100 < 40)
            prog[b][u*SW +: SW] = mkSlot(int'($urandom % 4), int'($urandom % 4),
                                         int'($urandom % 4), int'($urandom % 4));
        end
      end
      progLen = 12;
      runTest("R4 R5 R6 R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule